// File: doc/BRIEF.md
# Multiplexed Converter Readout Sequencer

This block is an SPI master that runs one measurement at a time on an external delta-sigma converter with a built-in analog input multiplexer. A client raises a one-cycle start strobe together with a channel number. The sequencer then takes these steps in order:

- It shifts a channel command byte out while chip select stays high.
- It waits at least one serial clock period.
- It pulls the shared chip select low, which both opens the converter's serial port and connects the chosen analog input.
- It waits, with the serial clock parked, for the converter to pull its data line low. That low level is the end-of-conversion flag.
- It clocks in a 32-bit result word MSB first and releases chip select, which also starts the converter's next conversion.

The result word is offered to the client with a one-cycle valid pulse. A busy level tells the client when a new start is accepted. An optional limit on the end-of-conversion wait ends a stuck measurement, releases chip select and raises a sticky error flag.

Top module: `muxAdcReader`

## Requirements
- R1: The command byte carries the channel number in bits 2:0, a 1 in bit 3 (value 0x08) and zeros in bits 7:4. It is sent MSB first on `mosi` while `csN` is high.
- R2: After the last falling `sck` edge of the command byte, `csN` stays high for at least one SCK period (2*CLK_DIV clock cycles) before it goes low.
- R3: While `csN` is low and `miso` has not yet gone low, no `sck` edge is produced. `miso` low while selected starts the readout.
- R4: The readout takes exactly 32 SCK cycles. The first bit sampled lands in `resultData[31]` and the last in `resultData[0]`.
- R5: `csN` rises after the 32nd bit. `resultValid` is a one-cycle pulse in the clock after `csN` rose, and `resultData` takes the new word at that pulse.
- R6: The SPI timing is mode 0. `sck` idles low, `miso` is sampled on the rising edge and `mosi` changes on the falling edge. One SCK period lasts 2*CLK_DIV clock cycles.
- R7: `mosi` is low whenever `csN` is low.
- R8: A `startReq` while `busy` is high is ignored. It starts no extra transfer and adds no extra result.
- R9: `busy` goes high in the clock after an accepted start and is low again by the time `resultValid` pulses.
- R10: If `miso` stays high for EOC_TIMEOUT cycles after `csN` falls (EOC_TIMEOUT > 0), the transfer is abandoned. `csN` returns high, `errFlag` is set and no `resultValid` pulse follows.
- R11: `errFlag` stays set until the next accepted start, which clears it.
- R12: During and after reset, `csN` is 1 and `sck`, `busy`, `resultValid` and `errFlag` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | One-cycle request to start a measurement |
| chanSel | input | CH_W | Analog channel for the measurement |
| busy | output | 1 | A measurement is in progress |
| resultData | output | RESULT_W | Last received result word |
| resultValid | output | 1 | One-cycle pulse: resultData is new |
| errFlag | output | 1 | Sticky end-of-conversion timeout flag |
| sck | output | 1 | Serial clock to the converter |
| mosi | output | 1 | Serial data to the converter |
| miso | input | 1 | Serial data and end-of-conversion flag from the converter |
| csN | output | 1 | Active-low select shared by the serial port and the multiplexer |

## Verification
The bench builds the block with CLK_DIV = 2, so one SCK period is four clock cycles and the bit timing, the select gap and the period can be measured edge by edge. It sets EOC_TIMEOUT = 200, so the abort path can be reached with a converter model that holds its data line high for 1000 cycles. A model that answers at once, with a zero-cycle end-of-conversion delay, exercises the tightest handover from the wait to the readout. The default CLK_DIV of 13 keeps SCK below 2 MHz from a 50 MHz clock and is used only for elaboration.

// File: rtl/muxAdcPkg.sv
package muxAdcPkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_CHAN, ST_GAP, ST_WAIT, ST_READ, ST_DONE
  } seqState_t;

  typedef struct packed {
    logic loadChan;
    logic loadRead;
    logic divRun;
    logic latchResult;
  } dpCtrl_t;
endpackage

// File: rtl/muxAdcDatapath.sv
module muxAdcDatapath
  import muxAdcPkg::*;
#(
  parameter int CLK_DIV  = 13,
  parameter int CH_W     = 3,
  parameter int EN_BIT   = 3,
  parameter int RESULT_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpCtrl_t             ctrl,
  input  logic [CH_W-1:0]     chanSel,
  input  logic                miso,
  output logic                sck,
  output logic                mosi,
  output logic                tick,
  output logic                shiftDone,
  output logic [RESULT_W-1:0] resultData,
  output logic                resultValid
);
  localparam int CMD_W = 8;
  localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int BIT_W = $clog2(RESULT_W + 1);

  logic [DIV_W-1:0]    divCnt;
  logic [CMD_W-1:0]    txShift;
  logic [RESULT_W-1:0] rxShift;
  logic [BIT_W-1:0]    bitsLeft;
  logic                sckReg;
  logic [CMD_W-1:0]    chanByte;

  assign chanByte  = CMD_W'(1 << EN_BIT) | CMD_W'(chanSel);
  assign tick      = ctrl.divRun && (divCnt == DIV_W'(CLK_DIV - 1));
  assign shiftDone = tick && sckReg && (bitsLeft == BIT_W'(1));
  assign sck       = sckReg;
  assign mosi      = txShift[CMD_W-1];

  // half-period divider, restarted by each load
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) divCnt <= '0;
    else if (!ctrl.divRun || ctrl.loadChan || ctrl.loadRead) divCnt <= '0;
    else if (divCnt == DIV_W'(CLK_DIV - 1)) divCnt <= '0;
    else divCnt <= divCnt + 1'b1;
  end

  // mode 0 shifter: sample on rise, advance on fall
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift  <= '0;
      rxShift  <= '0;
      bitsLeft <= '0;
      sckReg   <= 1'b0;
    end else if (ctrl.loadChan) begin
      txShift  <= chanByte;
      bitsLeft <= BIT_W'(CMD_W);
      sckReg   <= 1'b0;
    end else if (ctrl.loadRead) begin
      txShift  <= '0;
      rxShift  <= '0;
      bitsLeft <= BIT_W'(RESULT_W);
      sckReg   <= 1'b0;
    end else if (tick && bitsLeft != '0) begin
      if (!sckReg) begin
        sckReg  <= 1'b1;
        rxShift <= {rxShift[RESULT_W-2:0], miso};
      end else begin
        sckReg   <= 1'b0;
        txShift  <= {txShift[CMD_W-2:0], 1'b0};
        bitsLeft <= bitsLeft - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultData  <= '0;
      resultValid <= 1'b0;
    end else begin
      resultValid <= ctrl.latchResult;
      if (ctrl.latchResult) resultData <= rxShift;
    end
  end

  AST_SCK_PARKED: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.divRun |-> !sckReg); // R6
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid); // R5
endmodule

// File: rtl/muxAdcControl.sv
module muxAdcControl
  import muxAdcPkg::*;
#(
  parameter int EOC_TIMEOUT = 100000
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    startReq,
  input  logic    miso,
  input  logic    tick,
  input  logic    shiftDone,
  output dpCtrl_t ctrl,
  output logic    csN,
  output logic    busy,
  output logic    errFlag
);
  localparam int TO_W = (EOC_TIMEOUT > 1) ? $clog2(EOC_TIMEOUT) : 1;

  seqState_t state, nextState;
  logic      gapCnt;
  logic      toHit;
  logic      errSet;

  always_comb begin
    nextState = state;
    ctrl      = '0;
    errSet    = 1'b0;
    ctrl.divRun = (state == ST_CHAN) || (state == ST_GAP) ||
                  (state == ST_WAIT) || (state == ST_READ);
    case (state)
      ST_IDLE: if (startReq) begin
        nextState     = ST_CHAN;
        ctrl.loadChan = 1'b1;
      end
      ST_CHAN: if (shiftDone) nextState = ST_GAP;
      ST_GAP:  if (tick && gapCnt) nextState = ST_WAIT;
      ST_WAIT: begin
        if (!miso) begin
          nextState     = ST_READ;
          ctrl.loadRead = 1'b1;
        end else if (toHit) begin
          nextState = ST_IDLE;
          errSet    = 1'b1;
        end
      end
      ST_READ: if (shiftDone) nextState = ST_DONE;
      ST_DONE: begin
        ctrl.latchResult = 1'b1;
        nextState        = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      csN     <= 1'b1;
      gapCnt  <= 1'b0;
      errFlag <= 1'b0;
    end else begin
      state  <= nextState;
      csN    <= !((nextState == ST_WAIT) || (nextState == ST_READ));
      gapCnt <= (state == ST_GAP) ? (gapCnt ^ tick) : 1'b0;
      if (errSet) errFlag <= 1'b1;
      else if (ctrl.loadChan) errFlag <= 1'b0;
    end
  end

  assign busy = (state != ST_IDLE);

  if (EOC_TIMEOUT > 0) begin : g_timeout
    logic [TO_W-1:0] toCnt;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) toCnt <= '0;
      else if (state != ST_WAIT) toCnt <= '0;
      else toCnt <= toCnt + 1'b1;
    end
    assign toHit = (toCnt == TO_W'(EOC_TIMEOUT - 1));
  end else begin : g_noTimeout
    assign toHit = 1'b0;
  end

  AST_ERR_RELEASES_CS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errFlag) |-> csN); // R10
  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (busy && startReq) |=> !$fell(errFlag)); // R8
endmodule

// File: rtl/muxAdcReader.sv
module muxAdcReader
  import muxAdcPkg::*;
#(
  parameter int CLK_DIV     = 13,
  parameter int CH_W        = 3,
  parameter int EN_BIT      = 3,
  parameter int RESULT_W    = 32,
  parameter int EOC_TIMEOUT = 100000
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                startReq,
  input  logic [CH_W-1:0]     chanSel,
  output logic                busy,
  output logic [RESULT_W-1:0] resultData,
  output logic                resultValid,
  output logic                errFlag,
  output logic                sck,
  output logic                mosi,
  input  logic                miso,
  output logic                csN
);
  dpCtrl_t ctrl;
  logic    tick;
  logic    shiftDone;

  muxAdcControl #(.EOC_TIMEOUT(EOC_TIMEOUT)) u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .miso(miso),
    .tick(tick), .shiftDone(shiftDone), .ctrl(ctrl), .csN(csN),
    .busy(busy), .errFlag(errFlag)
  );

  muxAdcDatapath #(
    .CLK_DIV(CLK_DIV), .CH_W(CH_W), .EN_BIT(EN_BIT), .RESULT_W(RESULT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .chanSel(chanSel), .miso(miso),
    .sck(sck), .mosi(mosi), .tick(tick), .shiftDone(shiftDone),
    .resultData(resultData), .resultValid(resultValid)
  );

  AST_VALID_AFTER_CS: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> (csN && $past(csN))); // R5
  AST_MOSI_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !csN |-> !mosi); // R7
  AST_SELECT_NO_SCK: assert property (@(posedge clk) disable iff (!rstN)
    $fell(csN) |-> !sck); // R3
  AST_IDLE_NO_SELECT: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> csN); // R9
endmodule

// File: tb/muxAdcReader_bench.sv
module muxAdcReader_bench;
  localparam int CLK_DIV = 2;
  localparam int TO_LIM  = 200;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startReq = 1'b0;
  logic [2:0]  chanSel = '0;
  logic        busy, resultValid, errFlag, sck, mosi, csN;
  logic        miso = 1'b1;
  logic [31:0] resultData;

  muxAdcReader #(.CLK_DIV(CLK_DIV), .EOC_TIMEOUT(TO_LIM)) u_muxAdcReader (
    .clk(clk), .rstN(rstN), .startReq(startReq), .chanSel(chanSel),
    .busy(busy), .resultData(resultData), .resultValid(resultValid),
    .errFlag(errFlag), .sck(sck), .mosi(mosi), .miso(miso), .csN(csN)
  );

  always #10 clk = ~clk;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  typedef struct { logic [31:0] word; logic [7:0] cmd; } expItem_t;
  expItem_t expQ[$];

  // converter model
  longint      cyc = 0;
  logic [31:0] devWord = '0;
  int          eocDelay = 0;
  int          bitIdx = -1;
  logic [7:0]  chanRx = '0;
  logic [7:0]  chanSeen = '0;
  int          sckInWait = 0;
  longint      lastCmdFall = -1000;
  longint      lastRise = -1000;

  always @(posedge clk) cyc++;

  always @(posedge sck) begin
    if (lastRise >= 0 && (cyc - lastRise) <= 3 * CLK_DIV)
      check((cyc - lastRise) == 2 * CLK_DIV, "R6 sck period", cyc - lastRise, 2 * CLK_DIV);
    lastRise = cyc;
    if (csN) chanRx = {chanRx[6:0], mosi};
    else begin
      if (bitIdx < 0) sckInWait++;
      check(mosi == 1'b0, "R7 mosi low while selected", mosi, 0);
    end
  end

  always @(negedge sck) begin
    if (csN) lastCmdFall = cyc;
    else if (bitIdx > 0) begin
      bitIdx--;
      miso = devWord[bitIdx];
    end
  end

  always @(posedge csN) begin
    miso = 1'b1;
    bitIdx = -1;
  end

  initial begin
    forever begin
      @(negedge csN);
      chanSeen = chanRx;
      sckInWait = 0;
      check((cyc - lastCmdFall) >= 2 * CLK_DIV, "R2 select gap", cyc - lastCmdFall, 2 * CLK_DIV);
      for (int k = 0; k < eocDelay; k++) begin
        @(negedge clk);
        if (csN) break;
      end
      if (!csN) begin
        check(sckInWait == 0, "R3 no sck before end of conversion", sckInWait, 0);
        bitIdx = 31;
        miso = devWord[31];
      end
    end
  end

  // monitor / scoreboard
  bit prevValid = 1'b0;
  always @(negedge clk) begin
    if (rstN && resultValid) begin
      check(csN == 1'b1, "R5 csN high at valid", csN, 1);
      check(busy == 1'b0, "R9 busy low at valid", busy, 0);
      if (expQ.size() == 0) check(1'b0, "R8 unexpected result", resultData, 0);
      else begin
        expItem_t e;
        e = expQ.pop_front();
        check(resultData == e.word, "R4 result word", resultData, e.word);
        check(chanSeen == e.cmd, "R1 command byte", chanSeen, e.cmd);
      end
    end
    if (prevValid && resultValid) check(1'b0, "R5 valid longer than one cycle", 1, 0);
    prevValid = resultValid;
  end

  task automatic startOne(input logic [2:0] ch);
    @(negedge clk);
    while (busy) @(negedge clk);
    chanSel = ch;
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    check(busy == 1'b1, "R9 busy after start", busy, 1);
    check(errFlag == 1'b0, "R11 errFlag cleared by start", errFlag, 0);
  endtask

  task automatic runOne(input logic [2:0] ch, input logic [31:0] word, input int dly, input bit poke);
    expItem_t e;
    devWord = word;
    eocDelay = dly;
    e.word = word;
    e.cmd = 8'h08 | {5'b0, ch};
    expQ.push_back(e);
    startOne(ch);
    if (poke) begin
      repeat (20) @(negedge clk);
      chanSel = ~ch;
      startReq = 1'b1;   // R8: must be ignored
      @(negedge clk);
      startReq = 1'b0;
    end
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    check(csN == 1'b1, "R12 reset csN", csN, 1);
    check(sck == 1'b0, "R12 reset sck", sck, 0);
    check(busy == 1'b0, "R12 reset busy", busy, 0);
    check(resultValid == 1'b0, "R12 reset valid", resultValid, 0);
    check(errFlag == 1'b0, "R12 reset errFlag", errFlag, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(csN == 1'b1 && sck == 1'b0, "R12 idle after reset", {csN, sck}, 2'b10);

    runOne(3'd3, 32'h1234_5678, 5, 1'b0);
    runOne(3'd0, 32'h7FFF_FFFF, 3, 1'b0);
    runOne(3'd7, 32'h0000_0001, 0, 1'b0);
    runOne(3'd5, 32'h5A5A_A5A5, 12, 1'b1);
    check(expQ.size() == 0, "R8 no extra transfer", expQ.size(), 0);

    // timeout: converter never signals end of conversion
    devWord = 32'h0;
    eocDelay = 1000;
    startOne(3'd2);
    while (busy) @(negedge clk);
    check(errFlag == 1'b1, "R10 errFlag on timeout", errFlag, 1);
    check(csN == 1'b1, "R10 csN released on timeout", csN, 1);
    repeat (50) @(negedge clk);
    check(errFlag == 1'b1, "R11 errFlag sticky", errFlag, 1);
    check(chanSeen == 8'h0A, "R1 command byte before timeout", chanSeen, 8'h0A);

    runOne(3'd6, 32'h3C0F_F0C3, 7, 1'b0);
    check(expQ.size() == 0, "R4 all results received", expQ.size(), 0);

    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      check(1'b0, "watchdog expired", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule